// File: doc/BRIEF.md
# Masked Configuration Register Space

This block holds the 256-byte configuration register space of a single bus function. A requester presents a configuration address, a transfer length of one, two or four bytes and, for writes, a data word. The block first decodes the address: the bus field and the device/function field must both match the block's own parameters before anything happens. The low eight bits then give the starting byte offset. Bytes are stored and returned little-endian. The lowest data byte goes to the starting offset.

Every byte has a fixed writable-bit mask, and a write can only change the bits that mask allows. The identification bytes (vendor, device, revision, class, header type) are loaded from parameters at reset and can never be written. The six 32-bit base-address registers and the I/O and memory enable bits of the command register decide where the function is mapped, so any write that changes them raises a one-cycle remap request to the address-map logic. Reads are registered and return data one cycle after the request. Accesses are single-cycle strobes, with no back-pressure.

Top module: `cfg_space`

## Requirements
- R1: An access is selected only when address bits 23:16 equal BUS_NUM and bits 15:8 equal DEVFN. An unselected write changes nothing and raises no remap. An unselected read returns all ones in the requested width.
- R2: A read request loads rdata on the next clock edge, assembled little-endian from the starting offset, with the bytes above the requested width zero. rdata holds its value in every cycle without a read request.
- R3: A 4-byte read at an offset above 0xFC, a 2-byte read at an offset above 0xFE, or a read whose length is not 1, 2 or 4 returns all ones. That result is in the requested width, or the full 32 bits for an unsupported length.
- R4: A selected write with length 1, 2 or 4 updates consecutive bytes starting at the offset. Data byte 0 goes to the lowest offset, and each byte becomes (old AND NOT mask) OR (data AND mask). A write with any other length changes nothing.
- R5: Write bytes that would fall beyond offset 0xFF are dropped and do not wrap to offset 0x00.
- R6: After reset, offsets 0x00-0x01 hold VENDOR_ID, 0x02-0x03 hold DEVICE_ID, 0x08 holds REVISION, 0x09-0x0B hold CLASS_CODE and 0x0E holds HEADER_TYPE. These bytes are never writable. Every other byte resets to zero.
- R7: At offset 0x04 (command, low byte) only bit 0 (I/O enable), bit 1 (memory enable) and bit 2 (bus master) are writable. Offset 0x05 is read-only.
- R8: Offset 0x0C (cache line size), offset 0x3C (interrupt line) and every offset from 0x40 to 0xFF are fully writable.
- R9: The six base-address registers at 0x10-0x27 accept writes through the 32-bit mask BAR_WMASK, which is applied to each register.
- R10: remap is high for exactly the cycle after a selected write that changes any byte in 0x10-0x27, or changes bit 0 or bit 1 of offset 0x04. It stays low after a write that changes only the bus master bit, and after a write that stores equal values.
- R11: During and after reset, rdata and remap are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Config address: bus 23:16, device/function 15:8, offset 7:0 |
| len | input | 3 | Transfer length in bytes (1, 2 or 4) |
| wdata | input | 32 | Write data, low byte first |
| rdata | output | 32 | Registered read data |
| remap | output | 1 | One-cycle request to rebuild the address map |

## Verification
The hardest cases to reach are the remap rule and the edge of the space. For remap, the bench needs writes that touch a mapping field without changing it, and writes that change only the bus master bit; both must leave remap low. For the edge of the space, a 4-byte write starting at 0xFE must land only two bytes and leave the vendor ID at offset 0 intact. The stimulus first sets the command enables and one base register to known values. It then repeats identical writes and flips single bits, so each remap outcome follows from a single known byte difference. The boundary reads at 0xFC to 0xFF are issued after the wrapping write, so their expected values also show where the dropped bytes did not go.

// File: rtl/cfg_space.sv
module cfg_space #(
  parameter logic [7:0]  BUS_NUM     = 8'h00,
  parameter logic [7:0]  DEVFN       = 8'h18,
  parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0] DEVICE_ID   = 16'h5A17,
  parameter logic [7:0]  REVISION    = 8'h03,
  parameter logic [23:0] CLASS_CODE  = 24'h020000,
  parameter logic [7:0]  HEADER_TYPE = 8'h00,
  parameter logic [31:0] BAR_WMASK   = 32'hFFFF_FFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [31:0] addr,
  input  logic [2:0]  len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        remap
);

  localparam int NBYTES  = 256;
  localparam int LANES   = 4;
  localparam int BAR_LO  = 16;
  localparam int BAR_HI  = BAR_LO + 24 - 1;
  localparam int CMD_OFF = 4;

  function automatic logic [7:0] mask_of(input logic [7:0] a);
    logic [7:0] m;
    m = 8'h00;
    if (a >= 8'h40) m = 8'hFF;
    else if (a == 8'h0C || a == 8'h3C) m = 8'hFF;
    else if (a == 8'(CMD_OFF)) m = 8'h07;
    else if (int'(a) >= BAR_LO && int'(a) <= BAR_HI) m = BAR_WMASK[8*a[1:0] +: 8];
    return m;
  endfunction

  function automatic logic [7:0] init_of(input int a);
    logic [7:0] v;
    case (a)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      8:  v = REVISION;
      9:  v = CLASS_CODE[7:0];
      10: v = CLASS_CODE[15:8];
      11: v = CLASS_CODE[23:16];
      14: v = HEADER_TYPE;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

  logic [7:0] cfg [NBYTES];

  wire [7:0] off    = addr[7:0];
  wire       hit    = (addr[23:16] == BUS_NUM) && (addr[15:8] == DEVFN);
  wire       len_ok = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
  wire       do_wr  = req && wr && hit && len_ok;
  wire       do_rd  = req && !wr;

  logic [LANES-1:0] lane_en;
  logic [7:0]       lane_idx [LANES];
  logic [7:0]       lane_new [LANES];
  logic             bump;

  always_comb begin
    bump = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      logic [8:0] sum;
      logic [7:0] old, m;
      sum         = {1'b0, off} + 9'(i);
      lane_idx[i] = sum[7:0];
      lane_en[i]  = do_wr && (3'(i) < len) && !sum[8];
      old         = cfg[sum[7:0]];
      m           = mask_of(sum[7:0]);
      lane_new[i] = (old & ~m) | (wdata[8*i +: 8] & m);
      if (lane_en[i]) begin
        if (int'(sum[7:0]) >= BAR_LO && int'(sum[7:0]) <= BAR_HI && lane_new[i] != old)
          bump = 1'b1;
        if (int'(sum[7:0]) == CMD_OFF && ((lane_new[i] ^ old) & 8'h03) != 8'h00)
          bump = 1'b1;
      end
    end
  end

  logic [31:0] wmask_w;
  logic        rd_ok;
  logic [31:0] rd_val;

  assign wmask_w = (len == 3'd1) ? 32'h0000_00FF :
                   (len == 3'd2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rd_ok   = hit && ((len == 3'd1) ||
                           (len == 3'd2 && off <= 8'hFE) ||
                           (len == 3'd4 && off <= 8'hFC));

  always_comb begin
    rd_val = 32'h0;
    if (rd_ok) begin
      for (int i = 0; i < LANES; i++)
        if (3'(i) < len) rd_val[8*i +: 8] = cfg[off + 8'(i)];
    end else begin
      rd_val = wmask_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NBYTES; a++) cfg[a] <= init_of(a);
      rdata <= 32'h0;
      remap <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++)
        if (lane_en[i]) cfg[lane_idx[i]] <= lane_new[i];
      remap <= bump;
      if (do_rd) rdata <= rd_val;
    end
  end

endmodule

module cfg_space_chk #(
  parameter logic [7:0] BUS_NUM = 8'h00,
  parameter logic [7:0] DEVFN   = 8'h18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        wr,
  input logic [31:0] addr,
  input logic [2:0]  len,
  input logic [31:0] rdata,
  input logic        remap
);

  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |=> $stable(rdata));

  p_short_read_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && len == 3'd1) |=> (rdata[31:8] == 24'h0));

  p_bad_read_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && len == 3'd4 && addr[7:0] > 8'hFC) |=> (rdata == 32'hFFFF_FFFF));

  p_miss_read_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && len == 3'd4 && addr[15:8] != DEVFN) |=> (rdata == 32'hFFFF_FFFF));

  p_remap_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    remap |-> $past(req && wr && addr[23:16] == BUS_NUM && addr[15:8] == DEVFN));

endmodule

bind cfg_space cfg_space_chk #(.BUS_NUM(BUS_NUM), .DEVFN(DEVFN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
  .len(len), .rdata(rdata), .remap(remap)
);

// File: tb/cfg_space_tb_top.sv
`timescale 1ns/1ps
module cfg_space_tb_top;
  localparam logic [7:0] BUS = 8'h00;
  localparam logic [7:0] DF  = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] addr = '0;
  logic [2:0]  len = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        remap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_space dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .len(len), .wdata(wdata), .rdata(rdata), .remap(remap)
  );

  function automatic logic [31:0] ca(input logic [7:0] b, input logic [7:0] d, input logic [7:0] o);
    return {8'h00, b, d, o};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_acc(input logic [31:0] a, input logic [2:0] l, input logic [31:0] d,
                        output logic rm);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    rm = remap;
  endtask

  task automatic rd_acc(input logic [31:0] a, input logic [2:0] l, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a; len = l;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R11 rdata after reset", rdata, 32'h0);
    check("R11 remap after reset", {31'h0, remap}, 32'h0);
    rd_acc(ca(BUS, DF, 8'h00), 3'd4, d); check("R6 ids", d, 32'h5A17_C0DE);
    rd_acc(ca(BUS, DF, 8'h08), 3'd4, d); check("R6 class/rev", d, 32'h0200_0003);
    rd_acc(ca(BUS, DF, 8'h0C), 3'd4, d); check("R6 header zero", d, 32'h0);
    rd_acc(ca(BUS, DF, 8'h0E), 3'd1, d); check("R2 byte read", d, 32'h0);
  endtask

  task automatic t_readonly;
    logic [31:0] d; logic rm;
    wr_acc(ca(BUS, DF, 8'h00), 3'd4, 32'hFFFF_FFFF, rm);
    wr_acc(ca(BUS, DF, 8'h08), 3'd4, 32'hFFFF_FFFF, rm);
    wr_acc(ca(BUS, DF, 8'h0E), 3'd1, 32'h0000_00FF, rm);
    rd_acc(ca(BUS, DF, 8'h00), 3'd4, d); check("R6 ids read-only", d, 32'h5A17_C0DE);
    rd_acc(ca(BUS, DF, 8'h08), 3'd4, d); check("R6 class read-only", d, 32'h0200_0003);
    rd_acc(ca(BUS, DF, 8'h0E), 3'd1, d); check("R6 header read-only", d, 32'h0);
  endtask

  task automatic t_command;
    logic [31:0] d; logic rm;
    wr_acc(ca(BUS, DF, 8'h04), 3'd2, 32'h0000_FFFF, rm);
    check("R10 enables set remap", {31'h0, rm}, 32'h1);
    rd_acc(ca(BUS, DF, 8'h04), 3'd2, d); check("R7 command mask", d, 32'h0000_0007);
    wr_acc(ca(BUS, DF, 8'h04), 3'd1, 32'h0000_0003, rm);
    check("R10 master-only no remap", {31'h0, rm}, 32'h0);
    rd_acc(ca(BUS, DF, 8'h04), 3'd1, d); check("R7 master cleared", d, 32'h0000_0003);
    wr_acc(ca(BUS, DF, 8'h04), 3'd1, 32'h0000_0001, rm);
    check("R10 memory toggle remap", {31'h0, rm}, 32'h1);
  endtask

  task automatic t_writable;
    logic [31:0] d; logic rm;
    wr_acc(ca(BUS, DF, 8'h0C), 3'd1, 32'h0000_00AB, rm);
    wr_acc(ca(BUS, DF, 8'h3C), 3'd1, 32'h0000_005C, rm);
    rd_acc(ca(BUS, DF, 8'h0C), 3'd1, d); check("R8 cache line", d, 32'h0000_00AB);
    rd_acc(ca(BUS, DF, 8'h3C), 3'd4, d); check("R8 interrupt line", d, 32'h0000_005C);
    wr_acc(ca(BUS, DF, 8'h40), 3'd4, 32'h1122_3344, rm);
    check("R10 no remap device area", {31'h0, rm}, 32'h0);
    rd_acc(ca(BUS, DF, 8'h41), 3'd2, d); check("R4 little-endian word", d, 32'h0000_2233);
    rd_acc(ca(BUS, DF, 8'h43), 3'd1, d); check("R4 top byte", d, 32'h0000_0011);
    wr_acc(ca(BUS, DF, 8'h40), 3'd3, 32'hFFFF_FFFF, rm);
    rd_acc(ca(BUS, DF, 8'h40), 3'd4, d); check("R4 bad length write ignored", d, 32'h1122_3344);
    repeat (3) @(negedge clk);
    check("R2 rdata holds", rdata, 32'h1122_3344);
  endtask

  task automatic t_bar;
    logic [31:0] d; logic rm;
    wr_acc(ca(BUS, DF, 8'h10), 3'd4, 32'hFFFF_FFFF, rm);
    check("R10 bar change remap", {31'h0, rm}, 32'h1);
    rd_acc(ca(BUS, DF, 8'h10), 3'd4, d); check("R9 bar mask", d, 32'hFFFF_FFF0);
    wr_acc(ca(BUS, DF, 8'h10), 3'd4, 32'hFFFF_FFFF, rm);
    check("R10 same value no remap", {31'h0, rm}, 32'h0);
    wr_acc(ca(BUS, DF, 8'h24), 3'd1, 32'h0000_008F, rm);
    check("R10 last bar remap", {31'h0, rm}, 32'h1);
    rd_acc(ca(BUS, DF, 8'h24), 3'd4, d); check("R9 last bar", d, 32'h0000_0080);
  endtask

  task automatic t_edge;
    logic [31:0] d; logic rm;
    wr_acc(ca(BUS, DF, 8'hFE), 3'd4, 32'hDDCC_BBAA, rm);
    rd_acc(ca(BUS, DF, 8'hFE), 3'd2, d); check("R5 tail bytes", d, 32'h0000_BBAA);
    rd_acc(ca(BUS, DF, 8'h00), 3'd4, d); check("R5 no wrap", d, 32'h5A17_C0DE);
    rd_acc(ca(BUS, DF, 8'hFC), 3'd4, d); check("R3 last dword", d, 32'hBBAA_0000);
    rd_acc(ca(BUS, DF, 8'hFD), 3'd4, d); check("R3 dword past end", d, 32'hFFFF_FFFF);
    rd_acc(ca(BUS, DF, 8'hFF), 3'd2, d); check("R3 word past end", d, 32'h0000_FFFF);
    rd_acc(ca(BUS, DF, 8'hFF), 3'd1, d); check("R3 last byte", d, 32'h0000_00BB);
    rd_acc(ca(BUS, DF, 8'h00), 3'd3, d); check("R3 bad length read", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_decode;
    logic [31:0] d; logic rm;
    rd_acc(ca(BUS, 8'h20, 8'h00), 3'd2, d); check("R1 other function read", d, 32'h0000_FFFF);
    rd_acc(ca(8'h01, DF, 8'h00), 3'd4, d); check("R1 other bus read", d, 32'hFFFF_FFFF);
    wr_acc(ca(8'h01, DF, 8'h0C), 3'd1, 32'h0000_0077, rm);
    rd_acc(ca(BUS, DF, 8'h0C), 3'd1, d); check("R1 other bus write ignored", d, 32'h0000_00AB);
    wr_acc(ca(BUS, 8'h20, 8'h14), 3'd4, 32'h1234_5670, rm);
    check("R1 miss write no remap", {31'h0, rm}, 32'h0);
    rd_acc(ca(BUS, DF, 8'h14), 3'd4, d); check("R1 miss write bar", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R11 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    t_reset();
    t_readonly();
    t_command();
    t_writable();
    t_bar();
    t_edge();
    t_decode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule